// File: doc/BRIEF.md
# Three-Level Nested Interrupt Priority Controller

This block sits between a set of interrupt sources and a small processor core and decides which pending request, if any, is presented to the core. Each source has a pending latch that a one-cycle request pulse sets, an individual enable bit, and one priority-select bit. The select bit means different things for the two source groups. The two external pins can be placed at high or highest level. The eight peripheral sources can be placed at low or high level. The result is three levels, ordered low < high < highest.

A small in-service record holds one flag per level. A request is offered to the core only when its level is strictly above the highest level already being serviced. A running handler can therefore be preempted, and preemption can nest up to three deep. The core accepts an offered request with an acknowledge strobe, which marks the winner's level as in service and clears the winner's pending latch. A return strobe closes the innermost handler. A global enable masks the low and high levels. Highest-level sources answer only to their own enable bits.

Top module: `intc_nest3`

## Requirements
- R1: After a synchronous active-low reset all pending latches and in-service flags are clear and `irq` is low.
- R2: A high bit in `req_set` sets that source's pending latch at the clock edge. If the source is eligible and nothing is in service, `irq` is high in the following cycle.
- R3: Source indices 0 and 1 are the external pins, and `prio_sel` 0 gives high level while 1 gives highest. Indices 2 to 9 are peripherals, and `prio_sel` 0 gives low level while 1 gives high.
- R4: The winner is the eligible pending source at the greatest level. Among sources at that level, the lowest index wins. `vec_idx` carries the winner's index whenever `irq` is high.
- R5: `ack` while `irq` is high sets the in-service flag of the winner's level and clears the winner's pending latch. A `req_set` bit for the same source in the same cycle keeps the latch set. `ack` while `irq` is low has no effect.
- R6: `irq` is high only when the winner's level is strictly greater than the highest in-service level, which allows nesting three deep (low, then high, then highest).
- R7: `reti` clears the highest set in-service flag. With no flag set it has no effect. When `reti` and an accepted `ack` occur in the same cycle, both act.
- R8: While `glb_en` is low, sources at low and high level are not forwarded. Highest-level sources are still forwarded if their own enable is set.
- R9: A source whose `src_en` bit is low keeps its pending latch but is not forwarded. Setting the bit again makes it eligible at once.
- R10: A change of `prio_sel` applies to the arbitration in the same cycle and leaves the in-service flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 10 | Per-source request pulses that set the pending latches |
| src_en | input | 10 | Per-source enable |
| prio_sel | input | 10 | Per-source priority select (meaning per R3) |
| glb_en | input | 1 | Global enable for low and high levels |
| ack | input | 1 | Core acknowledge of the offered request |
| reti | input | 1 | Core return-from-interrupt strobe |
| irq | output | 1 | Request to the core |
| vec_idx | output | 4 | Index of the winning source |

## Verification
The assertions assume that every input has a known value on every clock edge after reset. They also assume that `vec_idx` is only meaningful while `irq` is high, so no property inspects it otherwise. Nothing is assumed about the core's behaviour: `ack` may arrive with `irq` low and `reti` may arrive with nothing in service. The stimulus deliberately includes such strobes, together with enable and priority changes made in the middle of nesting. All inputs are driven from reset onward on the falling edge with defined values, so no property sees unknown inputs.

// File: rtl/intc_pkg.sv
// Shared level encoding for the nested interrupt controller.
// Assumes: levels compare numerically, NONE below every real level.
package intc_pkg;
    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_TOP  = 2'd3
    } lvl_e;

    localparam int NUM_LVL = 3;
endpackage

// File: rtl/intc_pend.sv
// Pending-latch bank: one flag per source, set by request pulses and
// cleared by an accepted acknowledge. A set in the same cycle wins.
// Assumes: clr_idx is below N whenever clr_vld is high.
module intc_pend #(
    parameter int N  = 10,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_set,
    input  logic          clr_vld,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  pend
);
    logic [N-1:0] clr_mask;

    // Decode the clear index into a one-hot mask.
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign clr_mask[i] = clr_vld && (clr_idx == IW'(i));
    end

    // Update the latches: clear the accepted source, then merge new requests.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | req_set;
    end

    AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_set) |=> ((pend & $past(req_set)) == $past(req_set))); // R2
    AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !req_set[clr_idx]) |=> !pend[$past(clr_idx)]); // R5
endmodule

// File: rtl/intc_arb.sv
// Combinational arbiter: maps each source's select bit onto a level,
// applies the enables and finds the highest-level, lowest-index winner.
// Assumes: the first NUM_EXT sources are the external pins.
module intc_arb
    import intc_pkg::*;
#(
    parameter int N       = 10,
    parameter int NUM_EXT = 2,
    parameter int IW      = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  src_en,
    input  logic [N-1:0]  prio_sel,
    input  logic          glb_en,
    output logic          win_vld,
    output logic [IW-1:0] win_idx,
    output lvl_e          win_lvl
);
    lvl_e         src_lvl [N];
    logic [N-1:0] elig;

    // Map the select bit per group and qualify each source.
    for (genvar i = 0; i < N; i++) begin : g_src
        if (i < NUM_EXT) begin : g_ext
            assign src_lvl[i] = prio_sel[i] ? LVL_TOP : LVL_HIGH;
        end else begin : g_per
            assign src_lvl[i] = prio_sel[i] ? LVL_HIGH : LVL_LOW;
        end
        assign elig[i] = pend[i] && src_en[i] && (glb_en || (src_lvl[i] == LVL_TOP));
    end

    // Scan levels from highest down, lowest index first within a level.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        win_lvl = LVL_NONE;
        for (int l = NUM_LVL; l >= 1; l--) begin
            for (int i = 0; i < N; i++) begin
                if (!win_vld && elig[i] && (src_lvl[i] == lvl_e'(l))) begin
                    win_vld = 1'b1;
                    win_idx = IW'(i);
                    win_lvl = lvl_e'(l);
                end
            end
        end
    end

    AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (src_en[win_idx] && pend[win_idx])); // R9
    AST_GLB_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld && !glb_en) |-> (win_lvl == LVL_TOP)); // R8
    AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (int'(win_idx) < N)); // R4
endmodule

// File: rtl/intc_isr.sv
// In-service record: one flag per level. An accepted acknowledge sets
// the winner's level; a return clears the highest set flag.
// Assumes: set_lvl is never LVL_NONE when set_vld is high.
module intc_isr
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_vld,
    input  lvl_e             set_lvl,
    input  logic             drop,
    output logic [NUM_LVL:1] isr,
    output lvl_e             top_lvl
);
    logic [NUM_LVL:1] drop_mask;
    logic [NUM_LVL:1] set_mask;

    // Find the innermost (highest) level in service.
    always_comb begin
        top_lvl = LVL_NONE;
        for (int l = 1; l <= NUM_LVL; l++) begin
            if (isr[l]) top_lvl = lvl_e'(l);
        end
    end

    // Build the clear and set masks for this cycle.
    for (genvar l = 1; l <= NUM_LVL; l++) begin : g_mask
        assign drop_mask[l] = drop && (top_lvl == lvl_e'(l));
        assign set_mask[l]  = set_vld && (set_lvl == lvl_e'(l));
    end

    // Apply return first, then the new acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~drop_mask) | set_mask;
    end

    AST_SET_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |-> (set_lvl > top_lvl)); // R6
    AST_ACK_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> isr[$past(set_lvl)]); // R5
    AST_RETI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !set_vld && (|isr)) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R7
    AST_RETI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !set_vld && !(|isr)) |=> (isr == '0)); // R7
endmodule

// File: rtl/intc_nest3.sv
// Top of the three-level nested interrupt controller. Raises irq when
// the arbitration winner outranks every level in service; ack accepts it.
// Assumes: ack and reti are sampled on every edge and may be held high.
module intc_nest3
    import intc_pkg::*;
#(
    parameter int NUM_EXT = 2,
    parameter int NUM_PER = 8,
    localparam int N      = NUM_EXT + NUM_PER,
    localparam int IW     = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_set,
    input  logic [N-1:0]  src_en,
    input  logic [N-1:0]  prio_sel,
    input  logic          glb_en,
    input  logic          ack,
    input  logic          reti,
    output logic          irq,
    output logic [IW-1:0] vec_idx
);
    logic [N-1:0]     pend;
    logic             win_vld;
    logic [IW-1:0]    win_idx;
    lvl_e             win_lvl;
    logic [NUM_LVL:1] isr;
    lvl_e             top_lvl;
    logic             fire;

    intc_pend #(.N(N), .IW(IW)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_set (req_set),
        .clr_vld (fire),
        .clr_idx (win_idx),
        .pend    (pend)
    );

    intc_arb #(.N(N), .NUM_EXT(NUM_EXT), .IW(IW)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .src_en   (src_en),
        .prio_sel (prio_sel),
        .glb_en   (glb_en),
        .win_vld  (win_vld),
        .win_idx  (win_idx),
        .win_lvl  (win_lvl)
    );

    intc_isr u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vld (fire),
        .set_lvl (win_lvl),
        .drop    (reti),
        .isr     (isr),
        .top_lvl (top_lvl)
    );

    // Forward the winner only if it preempts the current handler.
    always_comb begin
        irq     = win_vld && (win_lvl > top_lvl);
        vec_idx = win_idx;
        fire    = ack && irq;
    end

    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq && !reti) |=> $stable(isr)); // R5
    AST_NO_SAME_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !isr[win_lvl]); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq && (isr == '0))); // R1
endmodule

// File: tb/sim_intc_nest3.sv
// Bench for intc_nest3: behavioural reference model compared every cycle.
module sim_intc_nest3;
    localparam int N = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] req_set = '0;
    logic [9:0] src_en = '0;
    logic [9:0] prio_sel = '0;
    logic       glb_en = 1'b0;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq;
    logic [3:0] vec_idx;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;
    string tag = "R1";

    // reference state
    bit  m_pend [N];
    bit  m_isr [4];   // index 1..3 used

    always #2 clk = ~clk;

    intc_nest3 u0 (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .src_en(src_en),
        .prio_sel(prio_sel), .glb_en(glb_en), .ack(ack), .reti(reti),
        .irq(irq), .vec_idx(vec_idx)
    );

    function automatic int lvl_of(int i);
        if (i < 2) return prio_sel[i] ? 3 : 2;
        return prio_sel[i] ? 2 : 1;
    endfunction

    function automatic int top_isr();
        int t = 0;
        for (int l = 1; l <= 3; l++) if (m_isr[l]) t = l;
        return t;
    endfunction

    // returns winner index or -1; level via wl
    function automatic int winner(output int wl);
        wl = 0;
        for (int l = 3; l >= 1; l--) begin
            for (int i = 0; i < N; i++) begin
                if (m_pend[i] && src_en[i] && (glb_en || lvl_of(i) == 3) && lvl_of(i) == l)
                    begin wl = l; return i; end
            end
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_pend[i] = 0;
        for (int l = 0; l < 4; l++) m_isr[l] = 0;
    endtask

    // compare outputs, then advance model over the next clock edge
    task automatic tick();
        int wl, wi, t;
        bit e_irq;
        #1;
        wi = winner(wl);
        t = top_isr();
        e_irq = (wi >= 0) && (wl > t) && rst_n;
        n_vec++;
        if (irq !== e_irq) begin
            n_bad++;
            $display("FAIL %s irq actual=%0b expected=%0b t=%0t", tag, irq, e_irq, $time);
        end else if (e_irq && vec_idx !== 4'(wi)) begin
            n_bad++;
            $display("FAIL %s vec_idx actual=%0d expected=%0d t=%0t", tag, vec_idx, wi, $time);
        end
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            if (reti && t > 0) m_isr[t] = 0;
            if (ack && e_irq) begin m_isr[wl] = 1; m_pend[wi] = 0; end
            for (int i = 0; i < N; i++) if (req_set[i]) m_pend[i] = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_set = '0; ack = 0; reti = 0;
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic pulse(logic [9:0] r);
        req_set = r; tick(); req_set = '0;
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic do_reti();
        reti = 1; tick(); reti = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        // R1: reset state, even with requests present
        tag = "R1"; req_set = '1; src_en = '1; glb_en = 1;
        tick(); tick();
        rst_n = 1; req_set = '0;
        idle(2);

        // R2: single request latches and raises irq next cycle
        tag = "R2"; pulse(10'b0000010000); idle(2);
        do_ack(); idle(1); do_reti(); idle(1);

        // R3 / R4: mixed levels and same-level tie break
        tag = "R3"; prio_sel = 10'b0000000000;
        pulse(10'b1000100100); idle(2);
        prio_sel = 10'b1000000000; idle(1);
        prio_sel = 10'b0000000001; pulse(10'b0000000011); idle(1);
        tag = "R4"; prio_sel = '0; idle(1);
        prio_sel = 10'b0000000010; idle(1);
        prio_sel = 10'b0000000011; idle(1);
        // drain everything
        for (int k = 0; k < 6; k++) begin do_ack(); do_reti(); end
        idle(2);

        // R6 / R5: three-deep nesting, then unwinding with R7
        tag = "R6"; prio_sel = 10'b0000100001;
        pulse(10'b0000001000); do_ack(); idle(1);   // low periph 3
        do_ack();                                   // ack with irq low: R5 ignore
        pulse(10'b0000010000); idle(1);             // low periph 4 blocked (same level)
        pulse(10'b0000100000); do_ack(); idle(1);   // high periph 5 preempts
        pulse(10'b0000000010); idle(1);             // ext1 high: blocked
        pulse(10'b0000000001); do_ack(); idle(1);   // ext0 highest preempts
        tag = "R5"; ack = 1; req_set = 10'b0000000001; tick(); ack = 0; req_set = '0;
        tag = "R10"; prio_sel = 10'b0000000000; idle(2); prio_sel = 10'b0000100001; idle(1);
        tag = "R7"; do_reti(); idle(1); do_reti(); idle(1);
        reti = 1; ack = 1; tick(); reti = 0; ack = 0; idle(1);
        for (int k = 0; k < 8; k++) begin do_reti(); do_ack(); end
        do_reti(); do_reti(); do_reti(); do_reti(); idle(2);

        // R8: global enable masks low/high but not highest
        tag = "R8"; glb_en = 0; prio_sel = 10'b0000000001;
        pulse(10'b0000010110); idle(2);
        do_ack(); idle(1); do_reti();
        prio_sel = 10'b0000000011; idle(2); do_ack(); do_reti();
        glb_en = 1; idle(2);
        for (int k = 0; k < 4; k++) begin do_ack(); do_reti(); end

        // R9: individual enable holds pending without forwarding
        tag = "R9"; src_en = 10'b1111110111; pulse(10'b0000001000); idle(3);
        src_en = '1; idle(1); do_ack(); do_reti(); idle(1);

        // random traffic exercising all rules together
        tag = "R4";
        for (int k = 0; k < 4000; k++) begin
            req_set  = ($urandom_range(0, 3) == 0) ? 10'($urandom) : '0;
            ack      = ($urandom_range(0, 2) == 0);
            reti     = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 15) == 0) prio_sel = 10'($urandom);
            if ($urandom_range(0, 31) == 0) src_en   = 10'($urandom) | 10'b1010101011;
            if ($urandom_range(0, 31) == 0) glb_en   = ~glb_en;
            tick();
        end
        idle(2);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule